// File: doc/BRIEF.md
# Pointer Page-Safety Flag Unit

This unit keeps a graded set of safety bits for every general register that holds a pointer. It works in step with the translation check. When a pointer is validated against the current page translation, the unit looks at the pointer's position inside its 4 KiB page. From that position it records which offset magnitudes can be applied in either direction without leaving the page.

Later, a load or store that names the register with a signed 8-bit immediate offset does not need a page-boundary comparison. The unit maps the magnitude of the offset to one grade and reads that grade's bit. It then reports either that the access may reuse the earlier translation, or that the pipeline must run the translation again. It also reports whether the access pays one extra cycle for the offset addition.

A translation change clears every register's bits at once. An ordinary register write that was not validated clears the bits of that register only.

Top module: `ptr_safe_flags`

## Requirements
- R1: After reset every register is unvalidated, so any check reports needs-translation and not safe.
- R2: A validated write of page offset P (low 12 bits of the pointer) to a register sets grade N (N = 1..8, stored at bit N-1) exactly when P >= 2^N-1 and P + 2^N-1 <= 4095. It also marks the register as validated.
- R3: The check offset is an 8-bit two's-complement value. The unit takes its magnitude M (1..128), selects the smallest N with 2^N-1 >= M, and reports safe only when grade N of the named register is set.
- R4: A zero offset is reported safe exactly when the named register is validated.
- R5: While a check is requested, the extra-latency output is 1 for a nonzero offset and 0 for a zero offset.
- R6: While a check is requested, exactly one of safe and needs-translation is high. With no check requested, safe, needs-translation and extra-latency are all 0.
- R7: A write without validation clears every grade and the validated mark of that register only. Other registers keep their state.
- R8: An invalidate-all request clears every register. It overrides a register write issued in the same cycle.
- R9: A write takes effect from the next clock edge. A check in the same cycle as a write to the same register sees the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 6 | Register written |
| wr_checked_i | input | 1 | 1: the write carries a validated pointer; 0: a plain write |
| wr_page_off_i | input | 12 | Low address bits of the validated pointer |
| inv_all_i | input | 1 | Translation changed: clear all registers |
| chk_en_i | input | 1 | Access-check request |
| chk_idx_i | input | 6 | Source register of the access |
| chk_off_i | input | 8 | Signed immediate offset of the access |
| chk_safe_o | output | 1 | Access may reuse the earlier translation |
| chk_need_xlat_o | output | 1 | Access must redo the translation check |
| chk_extra_lat_o | output | 1 | Access costs one extra cycle for offset addition |

## Verification
The bench builds the unit with its default parameters: 64 registers, 12 page-offset bits and 8-bit offsets, which gives 8 grades. With these values both page edges can be reached directly. The offset 0x80 (-128) exercises the top grade, and page offsets such as 0x0FE/0x0FF, 0xF00/0xF01 and 0xF80/0xF81 sit one step either side of a grade limit. Using the full 64-entry register file lets the vectors spread over many indices. This shows that plain writes and invalidates touch only the intended entries, and that a same-cycle write and check read the earlier contents.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int unsigned PSF_REGS      = 64;
  localparam int unsigned PSF_PAGE_BITS = 12;
  localparam int unsigned PSF_OFF_W     = 8;

  typedef enum logic [1:0] {
    VERD_IDLE = 2'b00,
    VERD_SAFE = 2'b01,
    VERD_XLAT = 2'b10
  } verdict_e;
endpackage

// File: rtl/psf_grade_calc.sv
module psf_grade_calc #(
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned GRADES    = 8
) (
  input  logic [PAGE_BITS-1:0] page_off_i,
  output logic [GRADES-1:0]    grade_o
);
  localparam int unsigned PAGE_MAX = (1 << PAGE_BITS) - 1;

  for (genvar g = 0; g < GRADES; g++) begin : g_grade
    localparam int unsigned SPAN = (1 << (g + 1)) - 1;
    localparam logic [PAGE_BITS-1:0] LO = PAGE_BITS'(SPAN);
    localparam logic [PAGE_BITS-1:0] HI = PAGE_BITS'(PAGE_MAX - SPAN);
    assign grade_o[g] = (page_off_i >= LO) && (page_off_i <= HI);
  end
endmodule

// File: rtl/psf_range_sel.sv
module psf_range_sel #(
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned GRADES = 8,
  localparam int unsigned GW    = (GRADES > 1) ? $clog2(GRADES) : 1
) (
  input  logic [OFF_W-1:0] off_i,
  output logic             zero_o,
  output logic [GW-1:0]    sel_o
);
  logic [OFF_W:0] mag;

  always_comb begin
    mag = off_i[OFF_W-1] ? ({1'b0, ~off_i} + 1'b1) : {1'b0, off_i};
    // -2^(OFF_W-1) negates to 2^(OFF_W-1) in OFF_W+1 bits
    if (off_i[OFF_W-1]) mag[OFF_W] = 1'b0;
    sel_o = GW'(GRADES - 1);
    for (int g = GRADES - 1; g >= 0; g--) begin
      if (mag <= (OFF_W + 1)'((1 << (g + 1)) - 1)) sel_o = GW'(g);
    end
  end

  assign zero_o = (off_i == '0);
endmodule

// File: rtl/psf_flag_store.sv
module psf_flag_store #(
  parameter int unsigned REGS   = 64,
  parameter int unsigned GRADES = 8,
  localparam int unsigned IW    = $clog2(REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_all_i,
  input  logic              wr_en_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic              wr_checked_i,
  input  logic [GRADES-1:0] wr_grade_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic              rd_valid_o,
  output logic [GRADES-1:0] rd_grade_o
);
  logic [REGS-1:0]             valid_q;
  logic [REGS-1:0][GRADES-1:0] grade_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      grade_q <= '0;
    end else if (inv_all_i) begin
      valid_q <= '0;
      grade_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= wr_checked_i;
      grade_q[wr_idx_i] <= wr_checked_i ? wr_grade_i : '0;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_grade_o = grade_q[rd_idx_i];
endmodule

// File: rtl/ptr_safe_flags.sv
module ptr_safe_flags
  import psf_pkg::*;
#(
  parameter int unsigned REGS      = PSF_REGS,
  parameter int unsigned PAGE_BITS = PSF_PAGE_BITS,
  parameter int unsigned OFF_W     = PSF_OFF_W,
  localparam int unsigned GRADES   = OFF_W,
  localparam int unsigned IW       = $clog2(REGS),
  localparam int unsigned GW       = (GRADES > 1) ? $clog2(GRADES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic                 wr_checked_i,
  input  logic [PAGE_BITS-1:0] wr_page_off_i,
  input  logic                 inv_all_i,
  input  logic                 chk_en_i,
  input  logic [IW-1:0]        chk_idx_i,
  input  logic [OFF_W-1:0]     chk_off_i,
  output logic                 chk_safe_o,
  output logic                 chk_need_xlat_o,
  output logic                 chk_extra_lat_o
);
  logic [GRADES-1:0] new_grade;
  logic [GRADES-1:0] rd_grade;
  logic              rd_valid;
  logic              off_zero;
  logic [GW-1:0]     sel;
  logic              ok;
  verdict_e          verdict;

  psf_grade_calc #(.PAGE_BITS(PAGE_BITS), .GRADES(GRADES)) u_calc (
    .page_off_i (wr_page_off_i),
    .grade_o    (new_grade)
  );

  psf_flag_store #(.REGS(REGS), .GRADES(GRADES)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inv_all_i    (inv_all_i),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_checked_i (wr_checked_i),
    .wr_grade_i   (new_grade),
    .rd_idx_i     (chk_idx_i),
    .rd_valid_o   (rd_valid),
    .rd_grade_o   (rd_grade)
  );

  psf_range_sel #(.OFF_W(OFF_W), .GRADES(GRADES)) u_sel (
    .off_i  (chk_off_i),
    .zero_o (off_zero),
    .sel_o  (sel)
  );

  assign ok = off_zero ? rd_valid : rd_grade[sel];

  always_comb begin
    if (!chk_en_i) verdict = VERD_IDLE;
    else if (ok)   verdict = VERD_SAFE;
    else           verdict = VERD_XLAT;
  end

  assign chk_safe_o      = (verdict == VERD_SAFE);
  assign chk_need_xlat_o = (verdict == VERD_XLAT);
  assign chk_extra_lat_o = chk_en_i && !off_zero;
endmodule

// File: rtl/psf_checker.sv
module psf_checker #(
  parameter int unsigned IW    = 6,
  parameter int unsigned OFF_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [IW-1:0]    wr_idx_i,
  input logic             wr_checked_i,
  input logic             inv_all_i,
  input logic             chk_en_i,
  input logic [IW-1:0]    chk_idx_i,
  input logic [OFF_W-1:0] chk_off_i,
  input logic             chk_safe_o,
  input logic             chk_need_xlat_o,
  input logic             chk_extra_lat_o
);
  assert_one_verdict_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_en_i |-> $countones({chk_safe_o, chk_need_xlat_o}) == 1);

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_en_i |-> !chk_safe_o && !chk_need_xlat_o && !chk_extra_lat_o);

  assert_zero_off_no_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_en_i && chk_off_i == '0) |-> !chk_extra_lat_o);

  assert_nonzero_off_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_en_i && chk_off_i != '0) |-> chk_extra_lat_o);

  assert_inv_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inv_all_i) && chk_en_i) |-> !chk_safe_o);

  assert_plain_write_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && !wr_checked_i) && chk_en_i && chk_idx_i == $past(wr_idx_i))
      |-> !chk_safe_o);
endmodule

bind ptr_safe_flags psf_checker #(.IW(IW), .OFF_W(OFF_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .wr_idx_i        (wr_idx_i),
  .wr_checked_i    (wr_checked_i),
  .inv_all_i       (inv_all_i),
  .chk_en_i        (chk_en_i),
  .chk_idx_i       (chk_idx_i),
  .chk_off_i       (chk_off_i),
  .chk_safe_o      (chk_safe_o),
  .chk_need_xlat_o (chk_need_xlat_o),
  .chk_extra_lat_o (chk_extra_lat_o)
);

// File: tb/sim_ptr_safe_flags.sv
module sim_ptr_safe_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic        wr_chk = 1'b0;
  logic [11:0] wr_pg = '0;
  logic        inv = 1'b0;
  logic        chk_en = 1'b0;
  logic [5:0]  chk_idx = '0;
  logic [7:0]  chk_off = '0;
  logic        safe, need, lat;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ptr_safe_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_checked_i(wr_chk), .wr_page_off_i(wr_pg), .inv_all_i(inv),
    .chk_en_i(chk_en), .chk_idx_i(chk_idx), .chk_off_i(chk_off),
    .chk_safe_o(safe), .chk_need_xlat_o(need), .chk_extra_lat_o(lat)
  );

  // {page offset, signed offset, expected safe}
  localparam int NV = 22;
  localparam logic [20:0] VEC [NV] = '{
    {12'h800, 8'h00, 1'b1}, {12'h800, 8'h7F, 1'b1}, {12'h800, 8'h80, 1'b1},
    {12'h000, 8'h00, 1'b1}, {12'h000, 8'h01, 1'b0}, {12'h000, 8'hFF, 1'b0},
    {12'hFFF, 8'h01, 1'b0}, {12'hFFF, 8'h00, 1'b1}, {12'h0FF, 8'h80, 1'b1},
    {12'h0FE, 8'h80, 1'b0}, {12'h0FE, 8'h7F, 1'b1}, {12'hF00, 8'h80, 1'b1},
    {12'hF01, 8'h80, 1'b0}, {12'hF01, 8'h7F, 1'b1}, {12'h003, 8'h03, 1'b1},
    {12'h003, 8'h04, 1'b0}, {12'h003, 8'hFE, 1'b1}, {12'hF80, 8'h7F, 1'b1},
    {12'hF81, 8'h7F, 1'b0}, {12'h03F, 8'hC1, 1'b1}, {12'h03E, 8'hE0, 1'b0},
    {12'h03E, 8'hE1, 1'b1}
  };

  task automatic put_write(input logic [5:0] idx, input logic c, input logic [11:0] pg);
    @(negedge clk);
    chk_en = 1'b0; inv = 1'b0;
    wr_en = 1'b1; wr_idx = idx; wr_chk = c; wr_pg = pg;
  endtask

  task automatic put_check(input logic [5:0] idx, input logic [7:0] off,
                           input logic exp_safe, input string req);
    logic exp_lat;
    @(negedge clk);
    wr_en = 1'b0; inv = 1'b0;
    chk_en = 1'b1; chk_idx = idx; chk_off = off;
    #1;
    exp_lat = (off != 8'h00);
    checks++;
    if (safe !== exp_safe || need !== !exp_safe || lat !== exp_lat) begin
      errors++;
      $display("FAIL %s reg=%0d off=%h: safe/need/lat=%b%b%b expected %b%b%b",
               req, idx, off, safe, need, lat, exp_safe, !exp_safe, exp_lat);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    put_check(6'd0, 8'h00, 1'b0, "R1");
    put_check(6'd63, 8'h10, 1'b0, "R1");

    // R6: idle outputs
    @(negedge clk);
    chk_en = 1'b0; chk_off = 8'h05;
    #1;
    checks++;
    if ({safe, need, lat} !== 3'b000) begin
      errors++;
      $display("FAIL R6 idle: outputs=%b expected 000", {safe, need, lat});
    end

    // R2 R3 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      logic [5:0] r;
      r = 6'((i * 5) % 64);
      put_write(r, 1'b1, VEC[i][20:9]);
      put_check(r, VEC[i][8:1], VEC[i][0], "R2/R3/R4/R5");
    end

    // R7: plain write clears only its own register
    put_write(6'd10, 1'b1, 12'h800);
    put_write(6'd11, 1'b1, 12'h800);
    put_write(6'd10, 1'b0, 12'h800);
    put_check(6'd10, 8'h00, 1'b0, "R7");
    put_check(6'd11, 8'h05, 1'b1, "R7");

    // R9: same-cycle write and check read earlier contents
    @(negedge clk);
    inv = 1'b0;
    wr_en = 1'b1; wr_idx = 6'd62; wr_chk = 1'b1; wr_pg = 12'h800;
    chk_en = 1'b1; chk_idx = 6'd62; chk_off = 8'h00;
    #1;
    checks++;
    if (safe !== 1'b0 || need !== 1'b1) begin
      errors++;
      $display("FAIL R9 same cycle: safe/need=%b%b expected 01", safe, need);
    end
    put_check(6'd62, 8'h40, 1'b1, "R9");

    // R8: invalidate-all beats a same-cycle write
    @(negedge clk);
    chk_en = 1'b0;
    inv = 1'b1;
    wr_en = 1'b1; wr_idx = 6'd30; wr_chk = 1'b1; wr_pg = 12'h800;
    put_check(6'd11, 8'h00, 1'b0, "R8");
    put_check(6'd30, 8'h00, 1'b0, "R8");
    put_check(6'd62, 8'h01, 1'b0, "R8");

    @(negedge clk);
    chk_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule